// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose integer registers and the floating-point registers of a processor core, each with a hidden second copy that takes over when a mode bit flips. The integer side has sixteen visible 32-bit registers. Indices 8 to 15 are a single shared set. Indices 0 to 7 come from one of two physical banks, chosen by the register-bank bit of the status word. The floating-point side has sixteen visible registers. All sixteen are banked against an extended set, chosen by the bank bit of the floating-point control word.

The core feeds in the two select bits directly: bit 29 of its status word and bit 21 of its floating-point control word. Changing a select bit does not copy any data. It only changes which physical copy each index decodes to. The change therefore takes effect in the same cycle, and a write in that cycle already lands in the newly selected copy. Privileged move instructions reach the hidden integer bank through a separate 3-bit port, and a further floating-point read port shows the hidden floating-point set. The status logic outside this block forces its bank bit to 1 on reset and on entry to an exception or interrupt. All storage clears to zero on reset.

Top module: `bank_regfile`

## Requirements
- R1: After reset every integer, alternate-bank and floating-point register reads as zero.
- R2: A write on the main write port stores into the register its 4-bit index selects in the active view. Both integer read ports return the new value from the next cycle on. The write is not visible in its own cycle.
- R3: Indices 8 to 15 name one shared set. The bank-select input has no effect on what they read or on where a write to them goes.
- R4: When the integer bank-select input differs from its value in the previous cycle, indices 0 to 7 at once return the copy that the alternate port returned before the change, and the alternate port then returns the previously active copy.
- R5: A main-port write to index 0 to 7, issued in the same cycle the integer bank-select changes, lands in the newly selected bank.
- R6: The alternate port reads and writes index 0 to 7 of the bank that is not selected. Its writes do not change what the main read ports return while the selection holds.
- R7: Changing the floating-point bank-select input makes all sixteen floating-point indices return their former extended copies in the same cycle, and the reverse.
- R8: The floating-point write port stores into the active set, visible from the next cycle. The extended read port always returns the set that is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_bank_sel | input | 1 | Status word bit 29: integer bank for indices 0 to 7 |
| fp_bank_sel | input | 1 | FP control word bit 21: front or extended FP set |
| rd_a_idx | input | 4 | Integer read port A index |
| rd_a_data | output | 32 | Integer read port A data, combinational |
| rd_b_idx | input | 4 | Integer read port B index |
| rd_b_data | output | 32 | Integer read port B data, combinational |
| wr_en | input | 1 | Integer write enable |
| wr_idx | input | 4 | Integer write index, active view |
| wr_data | input | 32 | Integer write data |
| alt_rd_idx | input | 3 | Hidden-bank read index |
| alt_rd_data | output | 32 | Hidden-bank read data |
| alt_wr_en | input | 1 | Hidden-bank write enable |
| alt_wr_idx | input | 3 | Hidden-bank write index |
| alt_wr_data | input | 32 | Hidden-bank write data |
| fp_rd_idx | input | 4 | FP read index, active set |
| fp_rd_data | output | 32 | FP read data, active set |
| fx_rd_idx | input | 4 | FP read index, extended (inactive) set |
| fx_rd_data | output | 32 | FP read data, inactive set |
| fp_wr_en | input | 1 | FP write enable |
| fp_wr_idx | input | 4 | FP write index, active set |
| fp_wr_data | input | 32 | FP write data |

## Verification
The properties assume that the select bits and all indices are driven to known values in every cycle. They also assume that the select bits are not toggled during reset. Under these conditions the previous-cycle select value is well defined, and the swap and write-visibility relations can be checked one cycle apart. The stimulus draws every index modulo its port's range. It holds both select bits steady while reset is asserted and flips them only at chosen cycles. Flips are rare enough that stretches with a steady selection occur, which exercises the write-landing and hidden-port properties between swaps.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Physical slot of an integer index: bank 0 low regs at 0..LOW-1,
  // bank 1 low regs at LOW..2*LOW-1, shared regs after both banks.
  function automatic int unsigned int_slot(int unsigned idx, logic bank,
                                           int unsigned low_n);
    if (idx < low_n) return bank ? idx + low_n : idx;
    return idx + low_n;
  endfunction

  // Physical slot of an FP index: front set first, extended set after it.
  function automatic int unsigned fp_slot(int unsigned idx, logic bank,
                                          int unsigned set_n);
    return bank ? idx + set_n : idx;
  endfunction

endpackage

// File: rtl/bank_edge.sv
module bank_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic flip
);
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= RST_VAL;
    else        sel_q <= sel;
  end

  assign flip = sel ^ sel_q;
endmodule

// File: rtl/int_bank_file.sv
module int_bank_file
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOW_N  = 8,
  parameter int VIS_N  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bank,
  input  logic [$clog2(VIS_N)-1:0]   ra_idx,
  output logic [DATA_W-1:0]          ra_data,
  input  logic [$clog2(VIS_N)-1:0]   rb_idx,
  output logic [DATA_W-1:0]          rb_data,
  input  logic                       we,
  input  logic [$clog2(VIS_N)-1:0]   w_idx,
  input  logic [DATA_W-1:0]          w_data,
  input  logic [$clog2(LOW_N)-1:0]   xr_idx,
  output logic [DATA_W-1:0]          xr_data,
  input  logic                       xwe,
  input  logic [$clog2(LOW_N)-1:0]   xw_idx,
  input  logic [DATA_W-1:0]          xw_data
);
  localparam int PHYS_N = VIS_N + LOW_N;
  localparam int SLOT_W = $clog2(PHYS_N);

  logic [DATA_W-1:0] regs [PHYS_N];
  logic [SLOT_W-1:0] ra_slot, rb_slot, w_slot, xr_slot, xw_slot;

  assign ra_slot = SLOT_W'(int_slot(32'(ra_idx), bank, LOW_N));
  assign rb_slot = SLOT_W'(int_slot(32'(rb_idx), bank, LOW_N));
  assign w_slot  = SLOT_W'(int_slot(32'(w_idx), bank, LOW_N));
  assign xr_slot = SLOT_W'(int_slot(32'(xr_idx), ~bank, LOW_N));
  assign xw_slot = SLOT_W'(int_slot(32'(xw_idx), ~bank, LOW_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++) regs[i] <= '0;
    end else begin
      if (we)  regs[w_slot]  <= w_data;
      if (xwe) regs[xw_slot] <= xw_data;
    end
  end

  assign ra_data = regs[ra_slot];
  assign rb_data = regs[rb_slot];
  assign xr_data = regs[xr_slot];
endmodule

// File: rtl/fp_bank_file.sv
module fp_bank_file
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SET_N  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bank,
  input  logic [$clog2(SET_N)-1:0]   rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [$clog2(SET_N)-1:0]   xr_idx,
  output logic [DATA_W-1:0]          xr_data,
  input  logic                       we,
  input  logic [$clog2(SET_N)-1:0]   w_idx,
  input  logic [DATA_W-1:0]          w_data
);
  localparam int PHYS_N = 2 * SET_N;
  localparam int SLOT_W = $clog2(PHYS_N);

  logic [DATA_W-1:0] regs [PHYS_N];
  logic [SLOT_W-1:0] rd_slot, xr_slot, w_slot;

  assign rd_slot = SLOT_W'(fp_slot(32'(rd_idx), bank, SET_N));
  assign xr_slot = SLOT_W'(fp_slot(32'(xr_idx), ~bank, SET_N));
  assign w_slot  = SLOT_W'(fp_slot(32'(w_idx), bank, SET_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[w_slot] <= w_data;
    end
  end

  assign rd_data = regs[rd_slot];
  assign xr_data = regs[xr_slot];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int DATA_W = 32,
  parameter int LOW_N  = 8,
  parameter int VIS_N  = 16,
  parameter int FP_N   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      int_bank_sel,
  input  logic                      fp_bank_sel,
  input  logic [$clog2(VIS_N)-1:0]  rd_a_idx,
  output logic [DATA_W-1:0]         rd_a_data,
  input  logic [$clog2(VIS_N)-1:0]  rd_b_idx,
  output logic [DATA_W-1:0]         rd_b_data,
  input  logic                      wr_en,
  input  logic [$clog2(VIS_N)-1:0]  wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [$clog2(LOW_N)-1:0]  alt_rd_idx,
  output logic [DATA_W-1:0]         alt_rd_data,
  input  logic                      alt_wr_en,
  input  logic [$clog2(LOW_N)-1:0]  alt_wr_idx,
  input  logic [DATA_W-1:0]         alt_wr_data,
  input  logic [$clog2(FP_N)-1:0]   fp_rd_idx,
  output logic [DATA_W-1:0]         fp_rd_data,
  input  logic [$clog2(FP_N)-1:0]   fx_rd_idx,
  output logic [DATA_W-1:0]         fx_rd_data,
  input  logic                      fp_wr_en,
  input  logic [$clog2(FP_N)-1:0]   fp_wr_idx,
  input  logic [DATA_W-1:0]         fp_wr_data
);
  // Named swap events, brought out for the bound checker.
  logic int_flip;
  logic fp_flip;

  bank_edge #(.RST_VAL(1'b1)) u_int_edge (
    .clk(clk), .rst_n(rst_n), .sel(int_bank_sel), .flip(int_flip)
  );

  bank_edge #(.RST_VAL(1'b0)) u_fp_edge (
    .clk(clk), .rst_n(rst_n), .sel(fp_bank_sel), .flip(fp_flip)
  );

  int_bank_file #(.DATA_W(DATA_W), .LOW_N(LOW_N), .VIS_N(VIS_N)) u_int (
    .clk(clk), .rst_n(rst_n), .bank(int_bank_sel),
    .ra_idx(rd_a_idx), .ra_data(rd_a_data),
    .rb_idx(rd_b_idx), .rb_data(rd_b_data),
    .we(wr_en), .w_idx(wr_idx), .w_data(wr_data),
    .xr_idx(alt_rd_idx), .xr_data(alt_rd_data),
    .xwe(alt_wr_en), .xw_idx(alt_wr_idx), .xw_data(alt_wr_data)
  );

  fp_bank_file #(.DATA_W(DATA_W), .SET_N(FP_N)) u_fp (
    .clk(clk), .rst_n(rst_n), .bank(fp_bank_sel),
    .rd_idx(fp_rd_idx), .rd_data(fp_rd_data),
    .xr_idx(fx_rd_idx), .xr_data(fx_rd_data),
    .we(fp_wr_en), .w_idx(fp_wr_idx), .w_data(fp_wr_data)
  );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int DATA_W = 32,
  parameter int LOW_N  = 8,
  parameter int VIS_N  = 16,
  parameter int FP_N   = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     int_flip,
  input logic                     fp_flip,
  input logic [$clog2(VIS_N)-1:0] rd_a_idx,
  input logic [DATA_W-1:0]        rd_a_data,
  input logic                     wr_en,
  input logic [$clog2(VIS_N)-1:0] wr_idx,
  input logic [DATA_W-1:0]        wr_data,
  input logic [$clog2(LOW_N)-1:0] alt_rd_idx,
  input logic [DATA_W-1:0]        alt_rd_data,
  input logic                     alt_wr_en,
  input logic [$clog2(LOW_N)-1:0] alt_wr_idx,
  input logic [DATA_W-1:0]        alt_wr_data,
  input logic [$clog2(FP_N)-1:0]  fp_rd_idx,
  input logic [DATA_W-1:0]        fp_rd_data,
  input logic [$clog2(FP_N)-1:0]  fx_rd_idx,
  input logic [DATA_W-1:0]        fx_rd_data,
  input logic                     fp_wr_en
);
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !int_flip && rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data)); // R2

  AST_SHARED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && 32'(rd_a_idx) >= LOW_N && $stable(rd_a_idx)) |-> $stable(rd_a_data)); // R3

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flip && !$past(wr_en) && !$past(alt_wr_en) && 32'(rd_a_idx) < LOW_N &&
     32'(rd_a_idx) == 32'($past(alt_rd_idx))) |-> rd_a_data == $past(alt_rd_data)); // R4

  AST_SWAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_flip) && $past(wr_en) && !int_flip && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data)); // R5

  AST_ALT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alt_wr_en) && !int_flip && alt_rd_idx == $past(alt_wr_idx))
      |-> alt_rd_data == $past(alt_wr_data)); // R6

  AST_FP_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_flip && !$past(fp_wr_en) && fp_rd_idx == $past(fx_rd_idx))
      |-> fp_rd_data == $past(fx_rd_data)); // R7
endmodule

bind bank_regfile regbank_chk #(
  .DATA_W(DATA_W), .LOW_N(LOW_N), .VIS_N(VIS_N), .FP_N(FP_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .int_flip(int_flip), .fp_flip(fp_flip),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .alt_rd_idx(alt_rd_idx), .alt_rd_data(alt_rd_data),
  .alt_wr_en(alt_wr_en), .alt_wr_idx(alt_wr_idx), .alt_wr_data(alt_wr_data),
  .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data),
  .fx_rd_idx(fx_rd_idx), .fx_rd_data(fx_rd_data),
  .fp_wr_en(fp_wr_en)
);

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        int_bank_sel = 1'b1, fp_bank_sel = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, alt_wr_en = 1'b0, fp_wr_en = 1'b0;
  logic [2:0]  alt_rd_idx = '0, alt_wr_idx = '0;
  logic [31:0] alt_rd_data, alt_wr_data = '0;
  logic [3:0]  fp_rd_idx = '0, fx_rd_idx = '0, fp_wr_idx = '0;
  logic [31:0] fp_rd_data, fx_rd_data, fp_wr_data = '0;

  bank_regfile u_dut (.*);

  // Model by data copy: visible view plus hidden copies, swapped on a change.
  logic [31:0] m_act [16];
  logic [31:0] m_alt [8];
  logic [31:0] m_fact [16];
  logic [31:0] m_fext [16];
  logic m_ib = 1'b1, m_fb = 1'b0;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called after inputs were set following a falling edge.
  task automatic step(input string tag);
    logic [31:0] t;
    if (int_bank_sel != m_ib) begin
      for (int i = 0; i < 8; i++) begin t = m_act[i]; m_act[i] = m_alt[i]; m_alt[i] = t; end
      m_ib = int_bank_sel;
    end
    if (fp_bank_sel != m_fb) begin
      for (int i = 0; i < 16; i++) begin t = m_fact[i]; m_fact[i] = m_fext[i]; m_fext[i] = t; end
      m_fb = fp_bank_sel;
    end
    #2;
    if (tag.len() != 0) begin
      chk(rd_a_data, m_act[rd_a_idx], {tag, " rd_a"});
      chk(rd_b_data, m_act[rd_b_idx], {tag, " rd_b"});
      chk(alt_rd_data, m_alt[alt_rd_idx], {tag, " alt_rd"});
      chk(fp_rd_data, m_fact[fp_rd_idx], {tag, " fp_rd"});
      chk(fx_rd_data, m_fext[fx_rd_idx], {tag, " fx_rd"});
    end else begin
      chk(rd_a_data, m_act[rd_a_idx], rd_a_idx < 8 ? "R2 R4 rd_a" : "R2 R3 rd_a");
      chk(rd_b_data, m_act[rd_b_idx], rd_b_idx < 8 ? "R2 R4 rd_b" : "R2 R3 rd_b");
      chk(alt_rd_data, m_alt[alt_rd_idx], "R6 alt_rd");
      chk(fp_rd_data, m_fact[fp_rd_idx], "R7 fp_rd");
      chk(fx_rd_data, m_fext[fx_rd_idx], "R8 fx_rd");
    end
    if (wr_en) m_act[wr_idx] = wr_data;
    if (alt_wr_en) m_alt[alt_wr_idx] = alt_wr_data;
    if (fp_wr_en) m_fact[fp_wr_idx] = fp_wr_data;
  endtask

  task automatic quiet();
    wr_en = 1'b0; alt_wr_en = 1'b0; fp_wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    for (int i = 0; i < 16; i++) begin m_act[i] = '0; m_fact[i] = '0; m_fext[i] = '0; end
    for (int i = 0; i < 8; i++) m_alt[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); alt_rd_idx = 3'(i);
      fp_rd_idx = 4'(i); fx_rd_idx = 4'(15 - i);
      step("R1");
    end

    // R5 directed: write during the cycle the bank flips
    @(negedge clk);
    int_bank_sel = ~int_bank_sel; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hA5A5_0003;
    rd_a_idx = 4'd3; alt_rd_idx = 3'd3;
    step("R5");
    @(negedge clk);
    quiet(); rd_a_idx = 4'd3; rd_b_idx = 4'd3; alt_rd_idx = 3'd3;
    step("R5");

    // R6 directed: hidden write leaves the visible register alone
    @(negedge clk);
    alt_wr_en = 1'b1; alt_wr_idx = 3'd3; alt_wr_data = 32'h0BAD_F00D;
    step("R6");
    @(negedge clk);
    quiet();
    step("R6");

    // R3 directed: shared register across a flip
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd12; wr_data = 32'h1234_5678;
    step("R3");
    @(negedge clk);
    quiet(); int_bank_sel = ~int_bank_sel; rd_a_idx = 4'd12;
    step("R3");

    // R7/R8 directed: FP write then flip
    @(negedge clk);
    fp_wr_en = 1'b1; fp_wr_idx = 4'd15; fp_wr_data = 32'h3F80_0000;
    step("R8");
    @(negedge clk);
    quiet(); fp_bank_sel = ~fp_bank_sel; fp_rd_idx = 4'd15; fx_rd_idx = 4'd15;
    step("R7");

    // Random mix, all requirements
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom % 5 == 0) int_bank_sel = ~int_bank_sel;
      if ($urandom % 6 == 0) fp_bank_sel = ~fp_bank_sel;
      wr_en = 1'($urandom % 2); wr_idx = 4'($urandom % 16); wr_data = $urandom;
      alt_wr_en = 1'($urandom % 3 == 0); alt_wr_idx = 3'($urandom % 8); alt_wr_data = $urandom;
      fp_wr_en = 1'($urandom % 2); fp_wr_idx = 4'($urandom % 16); fp_wr_data = $urandom;
      rd_a_idx = 4'($urandom % 16); rd_b_idx = 4'($urandom % 16);
      alt_rd_idx = 3'($urandom % 8);
      fp_rd_idx = 4'($urandom % 16); fx_rd_idx = 4'($urandom % 16);
      step("");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule